// File: doc/BRIEF.md
# Pipelined burst synchronous SRAM

A single-ported synchronous static memory with a pipelined read path. The data word is split into 8-bit byte lanes (four at the default 32-bit width). Address, chip selects, write controls and write data are all captured on the rising clock edge. Read data passes through an output register on the following edge, so the first word of a burst appears one cycle later than a flow-through memory would deliver it. After that first word, further words follow every cycle.

A transfer starts with one of two address strobes. The processor strobe always starts a read and is honoured only while the pipelining select is low. The controller strobe takes its read or write kind from the write controls on the same edge. After the start, an internal two-bit sequencer steps through the four-word block. It advances on each edge where the advance input is low, in either interleaved or linear order.

Reads and writes share one data path. It is modelled as an input bus and an output bus with a drive flag that stands in for the tri-state release. The output enable and the sleep input drop the drive flag at once, without waiting for a clock edge. The array depth is 2^ADDR_W words: ADDR_W=16 gives 64K words, and the default of 10 keeps elaboration small.

Top module: `pbs_top`

## Requirements
- R1: A controller-strobe write with gw_n low stores all of dq_i at the strobed address. A later read of that address returns the same word.
- R2: For a read accepted at edge k, dq_o holds the addressed word and dq_drive is high (with oe_n low) from edge k+1 until edge k+2. dq_drive is low between edge k and edge k+1 unless an earlier read is still being delivered.
- R3: A strobe is honoured as a selection only when ce1_n=0, ce2=1 and ce3_n=0. A strobe that sees any other combination performs no access, leaves dq_drive low after the next edge, and ends the burst, so that later advance edges make no access.
- R4: The processor strobe (adsp_n=0) is accepted only when ce1_n=0. It always starts a read, ignores gw_n, bwe_n and bw_n on that edge, and wins over a controller strobe on the same edge. With ce1_n=1 it is ignored.
- R5: Byte enables: gw_n=0 selects every lane. Otherwise, with bwe_n=0, lane i (bits 8i+7:8i, with bw_n[0] for bits 7:0) is written when bw_n[i]=0. A controller-strobe edge is a write when at least one lane is selected, and the write takes the data from dq_i on that edge.
- R6: On an edge with no accepted strobe and adv_n=0 during an active burst, the block goes to the next word. The upper address bits stay fixed. With lin_mode=0 the low two bits are start XOR count; with lin_mode=1 they are (start+count) mod 4.
- R7: On an edge with no accepted strobe and adv_n=1 during an active burst, the block accesses the same address again.
- R8: On an edge that continues a burst, the write controls on that edge choose between a write (of dq_i, to the selected lanes) and a read.
- R9: oe_n=1 forces dq_drive low in the same cycle, without a clock edge, and has no effect on the accesses themselves.
- R10: zz=1 forces dq_drive low at once. Edges seen while zz=1 perform no read or write and end the burst. The array contents are kept.
- R11: After rst_n is released, dq_drive is low and no burst is active.
- R12: A controller strobe with gw_n=1 and bwe_n=1 is a read, whatever bw_n holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address, sampled at an accepted strobe |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Pipelining chip select, active low |
| ce2 | input | 1 | Depth-expansion select, active high |
| ce3_n | input | 1 | Depth-expansion select, active low |
| gw_n | input | 1 | Global write of every lane, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | DATA_W/8 | Per-lane write selects, active low |
| lin_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Asynchronous sleep, active high |
| dq_i | input | DATA_W | Write data |
| dq_o | output | DATA_W | Registered read data |
| dq_drive | output | 1 | High while the block drives the data bus |

## Verification
A full-array fill with global writes is followed by directed bursts that start at an odd offset. Because the interleaved order (1,0,3,2) and the linear order (1,2,3,0) differ from each other and from a plain repeat of one address, these bursts show whether the sequencer steps and wraps correctly. Byte-lane writes with mixed masks, processor strobes issued with write controls asserted, and controller strobes with only bw_n low each show whether a stray lane is written or a stray write is taken. Deselects, the oe_n and zz pulses, and a long constrained-random mix of both strobes, advance, hold and continuation writes are checked every cycle against a reference array. This shows whether the data is wrong, or whether its timing is off by a cycle.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    localparam int CNT_W = 2;
endpackage

// File: rtl/pbs_wmask.sv
module pbs_wmask #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_en
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_en[l] = !gw_n || (!bwe_n && !bw_n[l]);
    end
endmodule

// File: rtl/pbs_seq.sv
module pbs_seq
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic [LANES-1:0]  lane_en,
    input  logic              lin_mode,
    input  logic              zz,
    input  logic [DATA_W-1:0] dq_i,
    output op_e               op_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [LANES-1:0]  wbe_o
);
    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        op_e               op;
        logic [ADDR_W-1:0] acc;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  wbe;
    } seq_t;

    seq_t seq_d, seq_q;

    logic adsp_ok, adsc_ok, selected, wr_req;

    function automatic logic [ADDR_W-1:0] burst_addr(
        input logic [ADDR_W-1:0] start,
        input logic [CNT_W-1:0]  step,
        input logic              linear
    );
        logic [CNT_W-1:0] low;
        low = linear ? start[CNT_W-1:0] + step : start[CNT_W-1:0] ^ step;
        return {start[ADDR_W-1:CNT_W], low};
    endfunction

    always_comb begin
        adsp_ok  = !adsp_n && !ce1_n;
        adsc_ok  = !adsc_n && !adsp_ok;
        selected = !ce1_n && ce2 && !ce3_n;
        wr_req   = |lane_en;
        seq_d    = seq_q;
        seq_d.op = OP_NONE;
        if (zz) begin
            seq_d.active = 1'b0;
        end else if (adsp_ok || adsc_ok) begin
            if (selected) begin
                seq_d.active = 1'b1;
                seq_d.base   = addr;
                seq_d.cnt    = '0;
                seq_d.wdata  = dq_i;
                if (adsp_ok) begin
                    seq_d.op  = OP_RD;
                    seq_d.wbe = '0;
                end else begin
                    seq_d.op  = wr_req ? OP_WR : OP_RD;
                    seq_d.wbe = lane_en;
                end
            end else begin
                seq_d.active = 1'b0;
            end
        end else if (seq_q.active) begin
            if (!adv_n) begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
            seq_d.op    = wr_req ? OP_WR : OP_RD;
            seq_d.wdata = dq_i;
            seq_d.wbe   = lane_en;
        end
        seq_d.acc = burst_addr(seq_d.base, seq_d.cnt, lin_mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign op_o       = seq_q.op;
    assign acc_addr_o = seq_q.acc;
    assign wdata_o    = seq_q.wdata;
    assign wbe_o      = seq_q.wbe;

    AST_ADSP_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && !adsp_n && !ce1_n && ce2 && !ce3_n) |=> (seq_q.op == OP_RD && seq_q.cnt == '0)); // R4
    AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && ((!adsp_n && !ce1_n) || !adsc_n) && !(!ce1_n && ce2 && !ce3_n))
        |=> (seq_q.op == OP_NONE && !seq_q.active)); // R3
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && seq_q.active && !(!adsp_n && !ce1_n) && adsc_n && !adv_n)
        |=> (seq_q.cnt == CNT_W'($past(seq_q.cnt) + 1'b1))); // R6
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && seq_q.active && !(!adsp_n && !ce1_n) && adsc_n && adv_n)
        |=> ($stable(seq_q.cnt) && $stable(seq_q.base))); // R7
    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        zz |=> (seq_q.op == OP_NONE && !seq_q.active)); // R10
endmodule

// File: rtl/pbs_array.sv
module pbs_array
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  wbe_i,
    input  logic              zz,
    output logic [DATA_W-1:0] dout_o,
    output logic              rd_valid_o
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] dout;
    } out_t;

    out_t out_d, out_q;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        out_d       = out_q;
        out_d.valid = !zz && (op_i == OP_RD);
        if (out_d.valid) begin
            out_d.dout = mem[addr_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!zz && op_i == OP_WR) begin
            for (int l = 0; l < LANES; l++) begin
                if (wbe_i[l]) begin
                    mem[addr_i][l*8 +: 8] <= wdata_i[l*8 +: 8];
                end
            end
        end
    end

    assign dout_o     = out_q.dout;
    assign rd_valid_o = out_q.valid;

    AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && op_i == OP_RD) |=> rd_valid_o); // R2
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (zz || op_i != OP_RD) |=> !rd_valid_o); // R3
endmodule

// File: rtl/pbs_top.sv
module pbs_top
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              lin_mode,
    input  logic              oe_n,
    input  logic              zz,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_drive
);
    logic [LANES-1:0]  lane_en;
    op_e               op;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] wdata;
    logic [LANES-1:0]  wbe;
    logic              rd_valid;

    pbs_wmask #(.LANES(LANES)) i_wmask (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_en (lane_en)
    );

    pbs_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .adsp_n     (adsp_n),
        .adsc_n     (adsc_n),
        .adv_n      (adv_n),
        .ce1_n      (ce1_n),
        .ce2        (ce2),
        .ce3_n      (ce3_n),
        .lane_en    (lane_en),
        .lin_mode   (lin_mode),
        .zz         (zz),
        .dq_i       (dq_i),
        .op_o       (op),
        .acc_addr_o (acc_addr),
        .wdata_o    (wdata),
        .wbe_o      (wbe)
    );

    pbs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .addr_i     (acc_addr),
        .wdata_i    (wdata),
        .wbe_i      (wbe),
        .zz         (zz),
        .dout_o     (dq_o),
        .rd_valid_o (rd_valid)
    );

    assign dq_drive = rd_valid && !oe_n && !zz;

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR) |=> !dq_drive); // R8
endmodule

// File: tb/test_pbs_top.sv
module test_pbs_top;
    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int LN    = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [LN-1:0] bw_n = '1;
    logic          lin_mode = 1'b0, oe_n = 1'b0, zz = 1'b0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_drive;

    int errors = 0;
    int checks = 0;
    string tag = "R11";

    pbs_top #(.ADDR_W(AW), .DATA_W(DW)) i_pbs_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .lin_mode(lin_mode), .oe_n(oe_n), .zz(zz),
        .dq_i(dq_i), .dq_o(dq_o), .dq_drive(dq_drive)
    );

    always #5 clk = ~clk;

    // reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    logic          m_active = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    int            m_op = 0;          // 0 none, 1 read, 2 write
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wd = '0;
    logic [LN-1:0] m_be = '0;
    logic          m_valid = 1'b0;
    logic [DW-1:0] m_dout = '0;

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] c, logic lin);
        logic [1:0] lo;
        lo = lin ? b[1:0] + c : b[1:0] ^ c;
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [LN-1:0] exp_lanes(logic g, logic e, logic [LN-1:0] b);
        if (!g) return '1;
        if (!e) return ~b;
        return '0;
    endfunction

    task automatic model_edge();
        logic [LN-1:0] be;
        logic pok, cok, sel;
        if (zz) begin
            m_valid = 1'b0;
        end else if (m_op == 2) begin
            for (int l = 0; l < LN; l++)
                if (m_be[l]) ref_mem[m_addr][l*8 +: 8] = m_wd[l*8 +: 8];
            m_valid = 1'b0;
        end else if (m_op == 1) begin
            m_dout  = ref_mem[m_addr];
            m_valid = 1'b1;
        end else begin
            m_valid = 1'b0;
        end
        be  = exp_lanes(gw_n, bwe_n, bw_n);
        pok = !adsp_n && !ce1_n;
        cok = !adsc_n && !pok;
        sel = !ce1_n && ce2 && !ce3_n;
        m_op = 0;
        if (zz) begin
            m_active = 1'b0;
        end else if (pok || cok) begin
            if (sel) begin
                m_active = 1'b1; m_base = addr; m_cnt = 2'd0;
                m_op = pok ? 1 : ((be != 0) ? 2 : 1);
                m_wd = dq_i; m_be = pok ? '0 : be;
            end else begin
                m_active = 1'b0;
            end
        end else if (m_active) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            m_op = (be != 0) ? 2 : 1;
            m_wd = dq_i; m_be = be;
        end
        m_addr = exp_addr(m_base, m_cnt, lin_mode);
    endtask

    task automatic compare();
        logic ed;
        ed = m_valid && !oe_n && !zz;
        checks++;
        if (dq_drive !== ed) begin
            errors++;
            $display("FAIL %s dq_drive actual=%0b expected=%0b at %0t", tag, dq_drive, ed, $time);
        end
        if (ed) begin
            checks++;
            if (dq_o !== m_dout) begin
                errors++;
                $display("FAIL %s dq_o actual=%h expected=%h at %0t", tag, dq_o, m_dout, $time);
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    endtask

    task automatic deselect();
        adsc_n = 1'b0; ce2 = 1'b0;
        step();
    endtask

    task automatic wr_word(logic [AW-1:0] a, logic [DW-1:0] d);
        adsc_n = 1'b0; addr = a; gw_n = 1'b0; dq_i = d;
        step();
    endtask

    task automatic rd_p(logic [AW-1:0] a);
        adsp_n = 1'b0; addr = a;
        step();
    endtask

    task automatic check_value(string t, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R11";
        compare();
        check_value("R11 drive after reset", {31'd0, dq_drive}, 32'd0);

        tag = "R1";
        for (int a = 0; a < DEPTH; a++) wr_word(AW'(a), $urandom());
        deselect();
        wr_word(10'h055, 32'hCAFE_F00D);
        deselect();
        rd_p(10'h055);
        tag = "R2";
        check_value("R2 not yet driving", {31'd0, dq_drive}, 32'd0);
        deselect();
        check_value("R2 first word", dq_o, 32'hCAFE_F00D);
        check_value("R1 word stored", dq_o, ref_mem[10'h055]);
        step();

        tag = "R4";
        adsp_n = 1'b0; addr = 10'h055; gw_n = 1'b0; dq_i = 32'h1111_1111;
        step();
        deselect();
        check_value("R4 adsp ignores write", dq_o, 32'hCAFE_F00D);
        adsp_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0; addr = 10'h056; dq_i = 32'h2222_2222;
        step();
        deselect();
        check_value("R4 adsp priority", dq_o, ref_mem[10'h056]);
        rd_p(10'h080);
        adsp_n = 1'b0; ce1_n = 1'b1; addr = 10'h100;
        step();
        step();
        check_value("R4 ignored adsp holds burst", dq_o, ref_mem[10'h080]);
        deselect();

        tag = "R5";
        wr_word(10'h0A0, 32'h0000_0000);
        adsc_n = 1'b0; addr = 10'h0A0; bwe_n = 1'b0; bw_n = 4'b1010; dq_i = 32'hAABB_CCDD;
        step();
        deselect();
        rd_p(10'h0A0);
        deselect();
        check_value("R5 lane mask 1010", dq_o, 32'h00BB_00DD);

        tag = "R12";
        adsc_n = 1'b0; addr = 10'h0A0; bw_n = 4'b0000; dq_i = 32'hFFFF_FFFF;
        step();
        deselect();
        check_value("R12 bw without bwe reads", dq_o, 32'h00BB_00DD);

        tag = "R6";
        lin_mode = 1'b0;
        rd_p(10'h0C1);
        for (int i = 0; i < 4; i++) begin adv_n = 1'b0; step(); end
        lin_mode = 1'b1;
        rd_p(10'h0C1);
        for (int i = 0; i < 4; i++) begin adv_n = 1'b0; step(); end
        deselect();

        tag = "R7";
        rd_p(10'h0C3);
        step(); step();
        check_value("R7 hold repeats", dq_o, ref_mem[10'h0C3]);
        deselect();

        tag = "R8";
        rd_p(10'h0D0);
        adv_n = 1'b0; gw_n = 1'b0; dq_i = 32'h1234_5678;
        step();
        adv_n = 1'b0;
        step();
        deselect();
        rd_p(10'h0D1);
        deselect();
        check_value("R8 continuation write", dq_o, 32'h1234_5678);

        tag = "R3";
        adsc_n = 1'b0; ce3_n = 1'b1; addr = 10'h010;
        step();
        adv_n = 1'b0;
        step();
        check_value("R3 deselected no drive", {31'd0, dq_drive}, 32'd0);
        adsp_n = 1'b0; ce2 = 1'b0; addr = 10'h011;
        step();
        step();
        deselect();

        tag = "R9";
        rd_p(10'h020);
        oe_n = 1'b1;
        step();
        check_value("R9 oe high releases", {31'd0, dq_drive}, 32'd0);
        oe_n = 1'b0;
        #1 check_value("R9 oe low drives", {31'd0, dq_drive}, 32'd1);
        deselect();

        tag = "R10";
        rd_p(10'h030);
        step();
        zz = 1'b1;
        #1 check_value("R10 zz releases", {31'd0, dq_drive}, 32'd0);
        gw_n = 1'b0; adsc_n = 1'b0; addr = 10'h030; dq_i = 32'hDEAD_BEEF;
        step();
        step();
        zz = 1'b0;
        deselect();
        rd_p(10'h030);
        deselect();
        check_value("R10 contents kept", dq_o, ref_mem[10'h030]);

        tag = "R6 random";
        for (int n = 0; n < 6000; n++) begin
            int unsigned r;
            r = $urandom() % 16;
            if (r < 2) adsp_n = 1'b0;
            else if (r < 4) adsc_n = 1'b0;
            addr = AW'($urandom());
            adv_n = $urandom() % 2 == 0;
            if ($urandom() % 10 == 0) begin
                ce1_n = $urandom() % 2 == 0; ce2 = $urandom() % 2 == 0; ce3_n = $urandom() % 2 == 0;
            end
            gw_n = $urandom() % 8 != 0;
            bwe_n = $urandom() % 2 == 0;
            bw_n = LN'($urandom());
            dq_i = $urandom();
            oe_n = $urandom() % 10 == 0;
            zz = $urandom() % 50 == 0;
            if (n % 500 == 0) lin_mode = ~lin_mode;
            step();
        end
        zz = 1'b0; oe_n = 1'b0;
        deselect();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule